// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block runs one access to a wide, paged register space that is reachable only through a small window of 16-bit management registers. A host hands it a page, a register offset within that page, a width code, a direction and up to 64 bits of write data. The block then issues the needed series of 16-bit management reads and writes on a request/acknowledge port. It returns a one-cycle response carrying a status code and, for reads, the assembled value.

The block remembers the last page it selected and skips the page-select write when the next access targets the same page. After each command it polls the command register until the busy bits clear. It waits a programmable number of cycles between polls and gives up after a fixed number of attempts. A failed management transaction stops the sequence at once.

Top module: `pgacc_seq`

## Requirements
- R1: After reset, req_ready is 1, mg_req is 0 and rsp_done is 0. The remembered page starts at all ones, so the first access always selects its page.
- R2: When the requested page differs from the remembered one, the first transaction writes {page, 8'h01} to register 0x10. The remembered page takes the new value only after that write is acknowledged without error.
- R3: When the requested page equals the remembered one, no write to register 0x10 is issued.
- R4: For writes, the data words go to registers 0x18, 0x19, ... in ascending order, with bits [15:0] of the value at 0x18. The word count is 1, 1, 2, 3 or 4 for width codes 0 (8 bit), 1 (16), 2 (32), 3 (48) and 4 (64). Codes 5 to 7 behave as code 4. For writes, the data words come before the command.
- R5: The command word {offset, 6'b0, op} is written to register 0x11, with op = 2'b01 for a write and 2'b10 for a read.
- R6: After the command, register 0x11 is read until bits [1:0] read as zero, up to 5 reads. If the fifth read still shows a busy bit, the access ends with status 2'b01 and no data registers are read.
- R7: Between two successive polls, mg_req is low for exactly poll_gap cycles. With poll_gap = 0 the polls follow back to back.
- R8: For reads, after completion the data registers are read in ascending order from 0x18. Register 0x18+i lands in bits [16i+15:16i]. An 8-bit read keeps only bits [7:0], and all bits above the requested width are zero.
- R9: A transaction acknowledged with mg_err ends the access immediately with status 2'b10, and no further transaction is issued. If the failing transaction was the page write, the remembered page is unchanged.
- R10: rsp_done is a one-cycle pulse. Status 2'b00 means success. rsp_rdata is zero for writes and for any access that did not succeed.
- R11: While mg_req is high and not yet acknowledged, mg_we, mg_reg and mg_wdata hold steady. req_ready is low while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_page | input | 8 | Target page |
| req_offset | input | 8 | Register offset within the page |
| req_width | input | 3 | Width code 0..4 = 8/16/32/48/64 bit |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write value, LSB aligned |
| poll_gap | input | 8 | Idle cycles between completion polls |
| mg_req | output | 1 | Management transaction request |
| mg_we | output | 1 | 1 = management write |
| mg_reg | output | 5 | Management register number |
| mg_wdata | output | 16 | Management write word |
| mg_ack | input | 1 | One-cycle transaction acknowledge |
| mg_err | input | 1 | Transaction failed, valid with mg_ack |
| mg_rdata | input | 16 | Read word, valid with mg_ack |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 00 ok, 01 poll timeout, 10 transaction fault |
| rsp_rdata | output | 64 | Read result, valid with rsp_done |

## Verification
The bench goes after the poll limit from both sides: four busy polls followed by a clear one, and five busy polls. A design with an off-by-one limit either times out on a good access or issues a sixth poll. It also forces a fault on the page-select write and then repeats the access. A design that updates the page cache too early would skip the required page write on the retry. Faults are also injected on a data word, on a poll and on a data read, where an abort that leaks would show up as extra transactions. Every width is run in both directions, which exposes reversed word order, a wrong word count or an 8-bit result that is not masked. The poll gap is measured in idle cycles, so a counter that is one cycle off is caught.

// File: rtl/pgacc_pkg.sv
package pgacc_pkg;

  localparam int MREG_W = 5;

  localparam logic [MREG_W-1:0] PAGE_SEL_REG  = 5'h10;
  localparam logic [MREG_W-1:0] CMD_REG       = 5'h11;
  localparam logic [MREG_W-1:0] DATA_BASE_REG = 5'h18;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] STS_OK      = 2'b00;
  localparam logic [1:0] STS_TIMEOUT = 2'b01;
  localparam logic [1:0] STS_FAULT   = 2'b10;

  typedef enum logic [2:0] {
    WID_8  = 3'd0,
    WID_16 = 3'd1,
    WID_32 = 3'd2,
    WID_48 = 3'd3,
    WID_64 = 3'd4
  } width_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_WDATA,
    ST_CMD,
    ST_POLL,
    ST_GAP,
    ST_RDATA,
    ST_RESP
  } seq_state_e;

  // number of 16-bit words moved for a width code
  function automatic logic [2:0] word_count(input logic [2:0] wcode);
    case (wcode)
      WID_8, WID_16: word_count = 3'd1;
      WID_32:        word_count = 3'd2;
      WID_48:        word_count = 3'd3;
      default:       word_count = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pgacc_page_cache.sv
module pgacc_page_cache #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic [PAGE_W-1:0] probe_page,
  output logic              miss
);

  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (upd_en) page_d = upd_page;
  end

  // all ones is never a real page, so the first probe misses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '1;
    else        page_q <= page_d;
  end

  assign miss = (probe_page != page_q);

  // R3
  page_hit_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && (probe_page == upd_page) |=> ($stable(probe_page) -> !miss));

endmodule

// File: rtl/pgacc_poll_timer.sv
module pgacc_poll_timer #(
  parameter int MAX_POLLS = 5,
  parameter int GAP_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             poll_ack,
  input  logic             gap_load,
  input  logic [GAP_W-1:0] gap_val,
  output logic             last_poll,
  output logic             gap_done
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [CNT_W-1:0] poll_cnt_q, poll_cnt_d;
  logic [GAP_W-1:0] gap_cnt_q, gap_cnt_d;

  always_comb begin
    poll_cnt_d = poll_cnt_q;
    if (clr)           poll_cnt_d = '0;
    else if (poll_ack) poll_cnt_d = poll_cnt_q + 1'b1;
  end

  always_comb begin
    gap_cnt_d = gap_cnt_q;
    if (gap_load)            gap_cnt_d = gap_val;
    else if (gap_cnt_q != 0) gap_cnt_d = gap_cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_cnt_q <= '0;
      gap_cnt_q  <= '0;
    end else begin
      poll_cnt_q <= poll_cnt_d;
      gap_cnt_q  <= gap_cnt_d;
    end
  end

  assign last_poll = (poll_cnt_q == CNT_W'(MAX_POLLS - 1));
  assign gap_done  = (gap_cnt_q <= GAP_W'(1));

  // R6
  poll_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> (poll_cnt_q < CNT_W'(MAX_POLLS)));

  // R7
  gap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_load |-> (gap_val != '0));

endmodule

// File: rtl/pgacc_word_path.sv
module pgacc_word_path #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [WORD_W*NWORDS-1:0] wdata_in,
  input  logic [$clog2(NWORDS)-1:0] sel,
  input  logic                     cap_en,
  input  logic [WORD_W-1:0]        cap_word,
  output logic [WORD_W-1:0]        wr_word,
  output logic [WORD_W*NWORDS-1:0] rd_value
);

  logic [WORD_W-1:0] wr_q [NWORDS];
  logic [WORD_W-1:0] rd_q [NWORDS];

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic [WORD_W-1:0] wr_d, rd_d;

    always_comb begin
      wr_d = wr_q[gi];
      if (load) wr_d = wdata_in[gi*WORD_W +: WORD_W];
    end

    always_comb begin
      rd_d = rd_q[gi];
      if (load)                               rd_d = '0;
      else if (cap_en && (int'(sel) == gi))   rd_d = cap_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_q[gi] <= '0;
        rd_q[gi] <= '0;
      end else begin
        wr_q[gi] <= wr_d;
        rd_q[gi] <= rd_d;
      end
    end

    assign rd_value[gi*WORD_W +: WORD_W] = rd_q[gi];
  end

  assign wr_word = wr_q[sel];

endmodule

// File: rtl/pgacc_seq.sv
module pgacc_seq
  import pgacc_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int WORD_W    = 16,
  parameter int NWORDS    = 4,
  parameter int MAX_POLLS = 5,
  parameter int GAP_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [PAGE_W-1:0]        req_page,
  input  logic [OFF_W-1:0]         req_offset,
  input  logic [2:0]               req_width,
  input  logic                     req_write,
  input  logic [WORD_W*NWORDS-1:0] req_wdata,
  input  logic [GAP_W-1:0]         poll_gap,
  output logic                     mg_req,
  output logic                     mg_we,
  output logic [MREG_W-1:0]        mg_reg,
  output logic [WORD_W-1:0]        mg_wdata,
  input  logic                     mg_ack,
  input  logic                     mg_err,
  input  logic [WORD_W-1:0]        mg_rdata,
  output logic                     rsp_done,
  output logic [1:0]               rsp_status,
  output logic [WORD_W*NWORDS-1:0] rsp_rdata
);

  localparam int DATA_W = WORD_W * NWORDS;
  localparam int IDX_W  = $clog2(NWORDS);

  seq_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [2:0]        wcode_q;
  logic              write_q;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic [1:0]        status_q, status_d;

  logic              accept, page_miss;
  logic              cache_upd, tmr_clr, poll_ack, gap_load, cap_en;
  logic              last_poll, gap_done, last_word;
  logic              xfer_ok, xfer_bad;
  logic [2:0]        n_words;
  logic [WORD_W-1:0] wr_word, page_word, cmd_word;
  logic [DATA_W-1:0] rd_full, rd_masked;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign xfer_ok   = mg_ack && !mg_err;
  assign xfer_bad  = mg_ack && mg_err;
  assign n_words   = word_count(wcode_q);
  assign last_word = (int'(widx_q) + 1 == int'(n_words));
  assign page_word = {page_q, {(WORD_W-PAGE_W-1){1'b0}}, 1'b1};
  assign cmd_word  = {off_q, {(WORD_W-OFF_W-2){1'b0}}, (write_q ? OP_WRITE : OP_READ)};

  pgacc_page_cache #(.PAGE_W(PAGE_W)) i_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (cache_upd),
    .upd_page   (page_q),
    .probe_page (req_page),
    .miss       (page_miss)
  );

  pgacc_poll_timer #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (tmr_clr),
    .poll_ack  (poll_ack),
    .gap_load  (gap_load),
    .gap_val   (poll_gap),
    .last_poll (last_poll),
    .gap_done  (gap_done)
  );

  pgacc_word_path #(.WORD_W(WORD_W), .NWORDS(NWORDS)) i_words (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .wdata_in (req_wdata),
    .sel      (widx_q),
    .cap_en   (cap_en),
    .cap_word (mg_rdata),
    .wr_word  (wr_word),
    .rd_value (rd_full)
  );

  // sequencing and management port drive
  always_comb begin
    state_d   = state_q;
    widx_d    = widx_q;
    status_d  = status_q;
    cache_upd = 1'b0;
    tmr_clr   = 1'b0;
    poll_ack  = 1'b0;
    gap_load  = 1'b0;
    cap_en    = 1'b0;
    mg_req    = 1'b0;
    mg_we     = 1'b0;
    mg_reg    = '0;
    mg_wdata  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_clr  = 1'b1;
          widx_d   = '0;
          status_d = STS_OK;
          if (page_miss)      state_d = ST_PAGE;
          else if (req_write) state_d = ST_WDATA;
          else                state_d = ST_CMD;
        end
      end
      ST_PAGE: begin
        mg_req   = 1'b1;
        mg_we    = 1'b1;
        mg_reg   = PAGE_SEL_REG;
        mg_wdata = page_word;
        if (xfer_bad) begin
          status_d = STS_FAULT;
          state_d  = ST_RESP;
        end else if (xfer_ok) begin
          cache_upd = 1'b1;
          state_d   = write_q ? ST_WDATA : ST_CMD;
        end
      end
      ST_WDATA: begin
        mg_req   = 1'b1;
        mg_we    = 1'b1;
        mg_reg   = DATA_BASE_REG + MREG_W'(widx_q);
        mg_wdata = wr_word;
        if (xfer_bad) begin
          status_d = STS_FAULT;
          state_d  = ST_RESP;
        end else if (xfer_ok) begin
          if (last_word) begin
            widx_d  = '0;
            state_d = ST_CMD;
          end else begin
            widx_d  = widx_q + 1'b1;
          end
        end
      end
      ST_CMD: begin
        mg_req   = 1'b1;
        mg_we    = 1'b1;
        mg_reg   = CMD_REG;
        mg_wdata = cmd_word;
        if (xfer_bad) begin
          status_d = STS_FAULT;
          state_d  = ST_RESP;
        end else if (xfer_ok) begin
          state_d  = ST_POLL;
        end
      end
      ST_POLL: begin
        mg_req = 1'b1;
        mg_reg = CMD_REG;
        if (xfer_bad) begin
          status_d = STS_FAULT;
          state_d  = ST_RESP;
        end else if (xfer_ok) begin
          poll_ack = 1'b1;
          if (mg_rdata[1:0] == 2'b00) begin
            widx_d  = '0;
            state_d = write_q ? ST_RESP : ST_RDATA;
          end else if (last_poll) begin
            status_d = STS_TIMEOUT;
            state_d  = ST_RESP;
          end else if (poll_gap != '0) begin
            gap_load = 1'b1;
            state_d  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gap_done) state_d = ST_POLL;
      end
      ST_RDATA: begin
        mg_req = 1'b1;
        mg_reg = DATA_BASE_REG + MREG_W'(widx_q);
        if (xfer_bad) begin
          status_d = STS_FAULT;
          state_d  = ST_RESP;
        end else if (xfer_ok) begin
          cap_en = 1'b1;
          if (last_word) state_d = ST_RESP;
          else           widx_d  = widx_q + 1'b1;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      widx_q   <= '0;
      status_q <= STS_OK;
    end else begin
      state_q  <= state_d;
      widx_q   <= widx_d;
      status_q <= status_d;
    end
  end

  // request capture, enabled on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      off_q   <= '0;
      wcode_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      page_q  <= req_page;
      off_q   <= req_offset;
      wcode_q <= req_width;
      write_q <= req_write;
    end
  end

  always_comb begin
    rd_masked = rd_full;
    if (wcode_q == WID_8) rd_masked = {{(DATA_W-8){1'b0}}, rd_full[7:0]};
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_done   = (state_q == ST_RESP);
  assign rsp_status = rsp_done ? status_q : STS_OK;
  assign rsp_rdata  = (rsp_done && (status_q == STS_OK) && !write_q) ? rd_masked : '0;

  // R11
  mg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mg_req && !mg_ack |=> mg_req && $stable(mg_we) && $stable(mg_reg) && $stable(mg_wdata));

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mg_req |-> !req_ready);

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mg_req && mg_ack && mg_err |=> !mg_req && rsp_done && (rsp_status == STS_FAULT));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_status != 2'b11));

endmodule

// File: tb/test_pgacc_seq.sv
module test_pgacc_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_page;
  logic [7:0]  req_offset;
  logic [2:0]  req_width;
  logic        req_write;
  logic [63:0] req_wdata;
  logic [7:0]  poll_gap;
  logic        mg_req, mg_we;
  logic [4:0]  mg_reg;
  logic [15:0] mg_wdata;
  logic        mg_ack, mg_err;
  logic [15:0] mg_rdata;
  logic        rsp_done;
  logic [1:0]  rsp_status;
  logic [63:0] rsp_rdata;

  always #10 clk = ~clk;

  pgacc_seq i_pgacc_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_offset(req_offset), .req_width(req_width),
    .req_write(req_write), .req_wdata(req_wdata), .poll_gap(poll_gap),
    .mg_req(mg_req), .mg_we(mg_we), .mg_reg(mg_reg), .mg_wdata(mg_wdata),
    .mg_ack(mg_ack), .mg_err(mg_err), .mg_rdata(mg_rdata),
    .rsp_done(rsp_done), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
  );

  int errors = 0;
  int checks = 0;
  string cur_tag = "R1";

  logic [21:0] exp_mg [$];   // {we, reg, wdata}
  logic [65:0] exp_rsp [$];  // {status, rdata}

  // switch-side model
  logic [7:0]  tb_cache = 8'hff;
  logic [7:0]  m_page = 8'h00;
  logic [15:0] m_cmd = 16'h0;
  logic [15:0] m_data [4];
  int          m_busy = 0;
  int          busy_cfg = 0;
  int          fault_at = -1;
  int          txn_idx = 0;
  int          lat = 0;
  int          wcnt = 0;
  int          idle = 0;
  int          gap_cfg = 0;
  bit          prev_poll = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fval(input logic [7:0] pg, input logic [7:0] off, input int i);
    return {pg ^ 8'(i * 37), off + 8'(i)};
  endfunction

  task automatic serve();
    logic [21:0] got, want;
    bit          is_poll;
    int          idx;
    got = {mg_we, mg_reg, mg_we ? mg_wdata : 16'h0};
    idx = txn_idx;
    txn_idx++;
    check(req_ready == 1'b0, "R11 ready while busy", 66'(req_ready), 66'h0);
    if (exp_mg.size() == 0) begin
      check(1'b0, {cur_tag, " unexpected transaction"}, 66'(got), 66'h0);
    end else begin
      want = exp_mg.pop_front();
      check(got == want, {cur_tag, " transaction"}, 66'(got), 66'(want));
    end
    is_poll = !mg_we && (mg_reg == 5'h11);
    if (is_poll && prev_poll)
      check(idle == gap_cfg, "R7 poll gap", 66'(idle), 66'(gap_cfg));
    prev_poll = is_poll;
    idle = 0;
    mg_rdata = 16'h0;
    if (idx == fault_at) begin
      mg_err = 1'b1;
    end else if (mg_we) begin
      if (mg_reg == 5'h10) m_page = mg_wdata[15:8];
      else if (mg_reg == 5'h11) begin
        m_cmd  = mg_wdata;
        m_busy = busy_cfg;
        if (mg_wdata[1:0] == 2'b10)
          for (int i = 0; i < 4; i++) m_data[i] = fval(m_page, mg_wdata[15:8], i);
      end else if (mg_reg >= 5'h18 && mg_reg <= 5'h1b) m_data[mg_reg - 5'h18] = mg_wdata;
    end else begin
      if (mg_reg == 5'h11) begin
        mg_rdata = (m_busy > 0) ? m_cmd : {m_cmd[15:8], 8'h00};
        if (m_busy > 0) m_busy--;
      end else if (mg_reg >= 5'h18 && mg_reg <= 5'h1b) mg_rdata = m_data[mg_reg - 5'h18];
    end
  endtask

  // management port responder, acts at falling edges
  initial begin
    mg_ack = 1'b0; mg_err = 1'b0; mg_rdata = 16'h0;
    forever begin
      @(negedge clk);
      if (mg_ack) begin
        mg_ack = 1'b0;
        mg_err = 1'b0;
        if (!mg_req) idle++;
      end else if (mg_req && rst_n) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          serve();
          mg_ack = 1'b1;
        end
      end else begin
        idle++;
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_done) begin
        if (exp_rsp.size() == 0) check(1'b0, {"R10/", cur_tag, " unexpected response"}, {rsp_status, rsp_rdata}, 66'h0);
        else begin
          logic [65:0] w;
          w = exp_rsp.pop_front();
          check({rsp_status, rsp_rdata} == w, {"R10/", cur_tag, " response"}, {rsp_status, rsp_rdata}, w);
        end
        @(negedge clk);
        check(!rsp_done, "R10 done pulse", 66'(rsp_done), 66'h0);
      end
    end
  end

  task automatic do_req(input string tag, input logic [7:0] pg, input logic [7:0] off,
                        input logic [2:0] wcode, input bit wr, input logic [63:0] wd,
                        input int busy, input int gap, input int fault, input int lt);
    logic [21:0] lst [$];
    int          n, polls;
    logic [1:0]  sts;
    logic [63:0] rd;
    bit          pg_wr;
    n = (wcode <= 1) ? 1 : (wcode == 2) ? 2 : (wcode == 3) ? 3 : 4;
    pg_wr = (pg != tb_cache);
    if (pg_wr) lst.push_back({1'b1, 5'h10, pg, 8'h01});
    if (wr) for (int i = 0; i < n; i++) lst.push_back({1'b1, 5'(5'h18 + i), wd[16*i +: 16]});
    lst.push_back({1'b1, 5'h11, off, 6'b0, (wr ? 2'b01 : 2'b10)});
    polls = (busy >= 5) ? 5 : busy + 1;
    for (int i = 0; i < polls; i++) lst.push_back({1'b0, 5'h11, 16'h0});
    if (busy < 5 && !wr) for (int i = 0; i < n; i++) lst.push_back({1'b0, 5'(5'h18 + i), 16'h0});
    if (fault >= 0 && fault < lst.size()) begin
      while (lst.size() > fault + 1) void'(lst.pop_back());
      sts = 2'b10;
    end else sts = (busy >= 5) ? 2'b01 : 2'b00;
    if (pg_wr && fault != 0) tb_cache = pg;
    rd = 64'h0;
    if (sts == 2'b00 && !wr) begin
      for (int i = 0; i < n; i++) rd[16*i +: 16] = fval(pg, off, i);
      if (wcode == 0) rd = rd & 64'hff;
    end
    foreach (lst[i]) exp_mg.push_back(lst[i]);
    exp_rsp.push_back({sts, rd});
    cur_tag = tag; busy_cfg = busy; gap_cfg = gap; fault_at = fault; lat = lt;
    txn_idx = 0; prev_poll = 1'b0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_page = pg; req_offset = off; req_width = wcode;
    req_write = wr; req_wdata = wd; poll_gap = 8'(gap);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_rsp.size() != 0) @(negedge clk);
    check(exp_mg.size() == 0, {tag, " missing transactions"}, 66'(exp_mg.size()), 66'h0);
    exp_mg.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_page = 0; req_offset = 0; req_width = 0;
    req_write = 0; req_wdata = 0; poll_gap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", 66'(req_ready), 66'h1);
    check(mg_req == 1'b0, "R1 no request after reset", 66'(mg_req), 66'h0);
    check(rsp_done == 1'b0, "R1 no done after reset", 66'(rsp_done), 66'h0);

    do_req("R2 first write16", 8'h03, 8'h20, 3'd1, 1'b1, 64'hbeef, 0, 0, -1, 0);
    do_req("R3 same page write8", 8'h03, 8'h21, 3'd0, 1'b1, 64'h5a, 1, 2, -1, 1);
    do_req("R4 write32", 8'h03, 8'h22, 3'd2, 1'b1, 64'h1234_5678, 0, 0, -1, 0);
    do_req("R4 write48", 8'h09, 8'h30, 3'd3, 1'b1, 64'h0000_a1a2_b3b4_c5c6, 2, 1, -1, 0);
    do_req("R4 write64", 8'h09, 8'h31, 3'd4, 1'b1, 64'hfedc_ba98_7654_3210, 0, 0, -1, 2);
    do_req("R8 read8", 8'h09, 8'h40, 3'd0, 1'b0, 64'h0, 2, 3, -1, 2);
    do_req("R8 read16", 8'h09, 8'h41, 3'd1, 1'b0, 64'h0, 0, 0, -1, 0);
    do_req("R8 read32", 8'h12, 8'h42, 3'd2, 1'b0, 64'h0, 0, 0, -1, 1);
    do_req("R8 read48", 8'h12, 8'h43, 3'd3, 1'b0, 64'h0, 1, 0, -1, 0);
    do_req("R8 read64", 8'h12, 8'h44, 3'd4, 1'b0, 64'h0, 3, 1, -1, 0);
    do_req("R6 four busy polls", 8'h12, 8'h45, 3'd2, 1'b0, 64'h0, 4, 0, -1, 0);
    do_req("R6 timeout write", 8'h12, 8'h46, 3'd1, 1'b1, 64'h7777, 7, 2, -1, 0);
    do_req("R6 timeout read", 8'h12, 8'h47, 3'd4, 1'b0, 64'h0, 5, 0, -1, 1);
    do_req("R9 page write fault", 8'h20, 8'h10, 3'd1, 1'b0, 64'h0, 0, 0, 0, 0);
    do_req("R9 retry selects page", 8'h20, 8'h10, 3'd1, 1'b0, 64'h0, 0, 0, -1, 0);
    do_req("R9 data word fault", 8'h20, 8'h11, 3'd2, 1'b1, 64'hcafe_f00d, 0, 0, 1, 0);
    do_req("R9 poll fault", 8'h20, 8'h12, 3'd2, 1'b0, 64'h0, 1, 1, 1, 0);
    do_req("R9 data read fault", 8'h20, 8'h13, 3'd4, 1'b0, 64'h0, 0, 0, 4, 1);
    do_req("R5 read top offset", 8'h20, 8'hff, 3'd1, 1'b0, 64'h0, 0, 0, -1, 0);
    do_req("R5 write after fault", 8'h21, 8'h00, 3'd5, 1'b1, 64'h1111_2222_3333_4444, 0, 0, -1, 0);

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule